// File: doc/BRIEF.md
# Split-Word Pin Controller with Edge Capture

This block controls 32 general-purpose pins split into two banks of 16, each bank decoded in its own address window of a simple single-cycle register bus. Six per-pin control registers set the pin behaviour: output level, output driver enable, input sampling enable, two auxiliary output routes and one auxiliary input route. Each control register is written as a split word. The lower half sets bits and the upper half clears bits, so software can change one pin without first reading the register.

Pin inputs pass through a two-stage synchroniser. The synchronised levels feed a read-back register and two sticky edge status registers, one for rising and one for falling transitions. Both status registers are cleared by writing ones. Four pins are reserved: they hold no state, read as zero and are never driven.

Top module: `pinbank_ctrl`

## Requirements
- R1: Pins 0–15 are addressed at byte offsets 0x00–0x20 and pins 16–31 at 0x80–0xA0. Within a bank the word offsets are: 0x00 output level, 0x04 driver enable, 0x08 input enable, 0x0C aux output route 1, 0x10 aux output route 2, 0x14 aux input route, 0x18 level read-back, 0x1C rising status, 0x20 falling status. Bank pin n is global pin n plus 16 times the bank number.
- R2: On a control register write, a 1 in data bit n (n < 16) sets that register's bit for bank pin n.
- R3: On a control register write, a 1 in data bit n+16 clears that register's bit for bank pin n. When both bits are 1 in one write, the bit ends up clear.
- R4: A data bit pair written as 0 in both halves leaves that control bit unchanged.
- R5: A read issued in one cycle returns the addressed bank register in bus_rdata[15:0] after the next clock edge. The upper 16 bits read as zero.
- R6: Global pins 23, 29, 30 and 31 are reserved. Writes to their bits are ignored, they read as 0 in every register, and pin_oe never drives them.
- R7: Output priority per pin: if aux route 1 is set, the pin drives aux_src1 with pin_oe=1. Otherwise, if aux route 2 is set, it drives aux_src2 with pin_oe=1. Otherwise, if the driver enable is set, it drives the output level bit. Otherwise pin_oe=0 and pin_out=0. Outputs are registered.
- R8: The read-back register returns the level of pin_in after two synchroniser flops, ANDed with input enable. A pin whose input enable is clear reads 0.
- R9: A rising (falling) transition of the synchronised level on an input-enabled pin sets its rising (falling) status bit. The bit stays set until cleared. Pins with input enable clear never set status.
- R10: Writing a 1 to lower-half bit n of a status register clears status bit n. The upper half of such a write, and writes to the read-back register, have no effect.
- R11: If a new edge is detected in the same cycle as a clear write to that status bit, the bit stays set.
- R12: aux_in_route is registered and equals the synchronised pin level ANDed with the aux input route bit.
- R13: After reset, all control and status bits are 0, pin_oe is 0 and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address, bit 7 selects the bank |
| bus_wdata | input | 32 | Write data: set half [15:0], clear half [31:16] |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin driver enables |
| aux_src1 | input | 32 | Auxiliary output source 1 |
| aux_src2 | input | 32 | Auxiliary output source 2 |
| aux_in_route | output | 32 | Synchronised pin levels passed to the auxiliary input consumer |

## Verification
The hardest case to reach is R11, where a clear write to a status bit must land on the same clock edge at which a new edge is latched. That edge is two synchroniser flops and one detection register away from the pin. The stimulus changes pin_in just after a falling clock edge and counts two rising edges. It then presents the clear write so that the third rising edge samples the write together with the detected transition. It also confirms that the same clear, issued with no edge arriving, does empty the bit.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int NUM_CTRL  = 6;
  localparam int REG_OUTV  = 0;
  localparam int REG_OE    = 1;
  localparam int REG_IE    = 2;
  localparam int REG_AO1   = 3;
  localparam int REG_AO2   = 4;
  localparam int REG_AI1   = 5;
  localparam int REG_LVL   = 6;
  localparam int REG_PEDGE = 7;
  localparam int REG_NEDGE = 8;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1_q;
  logic [N-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
#(
  parameter int           W     = 16,
  parameter int           IDX_W = 5,
  parameter logic [W-1:0] RSVD  = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic [2*W-1:0]                wdata,
  input  logic [W-1:0]                  lvl_sync,
  output logic [NUM_CTRL-1:0][W-1:0]    ctrl_o,
  output logic [W-1:0]                  rd_word
);
  logic [NUM_CTRL-1:0][W-1:0] ctrl_q;
  logic [W-1:0] pos_q, neg_q, prev_q;
  logic [W-1:0] set_h, clr_h, ie, rise, fall, pclr, nclr;

  assign set_h = wdata[W-1:0] & ~RSVD;
  assign clr_h = wdata[2*W-1:W];
  assign ie    = ctrl_q[REG_IE];
  assign rise  = lvl_sync & ~prev_q & ie;
  assign fall  = ~lvl_sync & prev_q & ie;
  assign pclr  = (wr_en && idx == IDX_W'(REG_PEDGE)) ? wdata[W-1:0] : '0;
  assign nclr  = (wr_en && idx == IDX_W'(REG_NEDGE)) ? wdata[W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pos_q  <= '0;
      neg_q  <= '0;
      prev_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++) begin
        if (wr_en && idx == IDX_W'(i))
          ctrl_q[i] <= (ctrl_q[i] | set_h) & ~clr_h;
      end
      prev_q <= lvl_sync;
      pos_q  <= (pos_q & ~pclr) | rise;
      neg_q  <= (neg_q & ~nclr) | fall;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (idx == IDX_W'(i)) rd_word = ctrl_q[i];
    if (idx == IDX_W'(REG_LVL))   rd_word = lvl_sync & ie;
    if (idx == IDX_W'(REG_PEDGE)) rd_word = pos_q;
    if (idx == IDX_W'(REG_NEDGE)) rd_word = neg_q;
  end

  assign ctrl_o = ctrl_q;

  // R3: a clear-half bit always leaves the output level bit at zero
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(REG_OUTV)) |=>
      ((ctrl_q[REG_OUTV] & $past(wdata[2*W-1:W])) == '0));

  // R4: an all-zero write changes nothing
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(REG_OE) && wdata == '0) |=> $stable(ctrl_q[REG_OE]));

  // R9: rising status is sticky without a clear write
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == IDX_W'(REG_PEDGE)) |=> ((pos_q & $past(pos_q)) == $past(pos_q)));

  // R11: a detected edge survives a simultaneous clear
  assert_edge_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((pos_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_bit,
  input  logic [N-1:0] drv_en,
  input  logic [N-1:0] route1,
  input  logic [N-1:0] route2,
  input  logic [N-1:0] src1,
  input  logic [N-1:0] src2,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  logic [N-1:0] nxt_out, nxt_oe;

  for (genvar p = 0; p < N; p++) begin : g_pin
    assign nxt_oe[p]  = route1[p] | route2[p] | drv_en[p];
    assign nxt_out[p] = route1[p] ? src1[p] :
                        route2[p] ? src2[p] :
                        drv_en[p] ? lvl_bit[p] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt_out;
      pin_oe  <= nxt_oe;
    end
  end

  // R7: an undriven pin presents zero
  assert_quiet_undriven_R7: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> ((pin_out & ~pin_oe) == '0));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int BANK_W    = 16,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter logic [NUM_BANKS*BANK_W-1:0] RSVD_MASK = 32'hE080_0000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [2*BANK_W-1:0]           bus_wdata,
  output logic [2*BANK_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
  output logic [NUM_BANKS*BANK_W-1:0]   pin_oe,
  input  logic [NUM_BANKS*BANK_W-1:0]   aux_src1,
  input  logic [NUM_BANKS*BANK_W-1:0]   aux_src2,
  output logic [NUM_BANKS*BANK_W-1:0]   aux_in_route
);
  localparam int NPINS  = NUM_BANKS * BANK_W;
  localparam int DATA_W = 2 * BANK_W;
  localparam int BSEL_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = ADDR_W - BSEL_W - 2;

  logic [BSEL_W-1:0] bsel;
  logic [IDX_W-1:0]  idx;
  logic [NPINS-1:0]  lvl_all, outv_all, oe_all, ao1_all, ao2_all, ai1_all;
  logic [NUM_BANKS-1:0][NUM_CTRL-1:0][BANK_W-1:0] ctrl_b;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rd_word_b;
  logic [BANK_W-1:0] rd_sel;
  logic [DATA_W-1:0] rdata_q;
  logic [NPINS-1:0]  route_q;

  assign bsel = bus_addr[ADDR_W-1 -: BSEL_W];
  assign idx  = bus_addr[ADDR_W-BSEL_W-1:2];

  pinbank_sync #(.N(NPINS)) u_sync (
    .clk (clk), .rst (rst), .d (pin_in), .q (lvl_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pinbank_bank #(
      .W     (BANK_W),
      .IDX_W (IDX_W),
      .RSVD  (RSVD_MASK[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_en && bus_we && bsel == BSEL_W'(b)),
      .idx      (idx),
      .wdata    (bus_wdata),
      .lvl_sync (lvl_all[b*BANK_W +: BANK_W]),
      .ctrl_o   (ctrl_b[b]),
      .rd_word  (rd_word_b[b])
    );
    assign outv_all[b*BANK_W +: BANK_W] = ctrl_b[b][REG_OUTV];
    assign oe_all  [b*BANK_W +: BANK_W] = ctrl_b[b][REG_OE];
    assign ao1_all [b*BANK_W +: BANK_W] = ctrl_b[b][REG_AO1];
    assign ao2_all [b*BANK_W +: BANK_W] = ctrl_b[b][REG_AO2];
    assign ai1_all [b*BANK_W +: BANK_W] = ctrl_b[b][REG_AI1];
  end

  pinbank_drive #(.N(NPINS)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .lvl_bit (outv_all),
    .drv_en  (oe_all),
    .route1  (ao1_all),
    .route2  (ao2_all),
    .src1    (aux_src1),
    .src2    (aux_src2),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bsel == BSEL_W'(b)) rd_sel = rd_word_b[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      route_q <= '0;
    end else begin
      if (bus_en && !bus_we) rdata_q <= {{BANK_W{1'b0}}, rd_sel};
      route_q <= lvl_all & ai1_all;
    end
  end

  assign bus_rdata    = rdata_q;
  assign aux_in_route = route_q;

  // R6: reserved pins are never driven
  assert_rsvd_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & RSVD_MASK) == '0);

  // R5: upper read half is always zero
  assert_rdata_upper_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:BANK_W] == '0);
endmodule

// File: tb/test_pinbank_ctrl.sv
module test_pinbank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0, aux_src1 = '0, aux_src2 = '0;
  logic [31:0] pin_out, pin_oe, aux_in_route;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  pinbank_ctrl i_pinbank_ctrl (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .aux_src1(aux_src1), .aux_src2(aux_src2), .aux_in_route(aux_in_route)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pin_in = '0; aux_src1 = '0; aux_src2 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_en = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R13 rdata after reset", bus_rdata, 32'h0);
    check("R13 pin_oe after reset", pin_oe, 32'h0);
    rd(8'h04, d); check("R13 low enable reg", d, 32'h0);
    rd(8'h9C, d); check("R13 high rising status", d, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    do_reset();
    wr(8'h00, 32'h0000_00A5); rd(8'h00, d); check("R2 set half", d, 32'h0000_00A5);
    wr(8'h00, 32'h0005_0000); rd(8'h00, d); check("R3 clear half", d, 32'h0000_00A0);
    wr(8'h00, 32'h0000_0000); rd(8'h00, d); check("R4 zero write holds", d, 32'h0000_00A0);
    wr(8'h00, 32'h0080_0080); rd(8'h00, d); check("R3 clear wins", d, 32'h0000_0020);
    wr(8'h80, 32'h0000_0003); rd(8'h80, d); check("R1 high bank window", d, 32'h0000_0003);
    rd(8'h00, d); check("R1 low bank untouched", d, 32'h0000_0020);
    wr(8'h18, 32'h0000_FFFF); rd(8'h00, d); check("R10 read-back write ignored", d, 32'h0000_0020);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    do_reset();
    wr(8'h84, 32'h0000_FFFF); rd(8'h84, d); check("R6 reserved bits read 0", d, 32'h0000_1F7F);
    repeat (3) @(negedge clk);
    check("R6 reserved pins undriven", pin_oe, 32'h1F7F_0000);
  endtask

  task automatic t_drive();
    do_reset();
    aux_src1 = 32'h0000_0004; aux_src2 = 32'h0000_0018;
    wr(8'h00, 32'h0000_0003);
    wr(8'h04, 32'h0000_0007);
    wr(8'h0C, 32'h0000_0014);
    wr(8'h10, 32'h0000_0018);
    repeat (3) @(negedge clk);
    check("R7 pin_oe priority", {26'h0, pin_oe[5:0]}, 32'h0000_001F);
    check("R7 pin_out priority", {26'h0, pin_out[5:0]}, 32'h0000_000F);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    do_reset();
    pin_in = 32'h0001_0005;
    repeat (4) @(negedge clk);
    rd(8'h18, d); check("R8 gated when input disabled", d, 32'h0);
    wr(8'h08, 32'h0000_0001); rd(8'h18, d); check("R8 low read-back", d, 32'h0000_0001);
    wr(8'h88, 32'h0000_0001); rd(8'h98, d); check("R8 high read-back", d, 32'h0000_0001);
    wr(8'h14, 32'h0000_0004);
    repeat (3) @(negedge clk);
    check("R12 aux input route", aux_in_route, 32'h0000_0004);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    do_reset();
    wr(8'h08, 32'h0000_0003);
    pin_in = 32'h0000_0001; repeat (5) @(negedge clk);
    rd(8'h1C, d); check("R9 rising latched", d, 32'h0000_0001);
    rd(8'h20, d); check("R9 no falling yet", d, 32'h0);
    pin_in = 32'h0000_0004; repeat (5) @(negedge clk);
    rd(8'h20, d); check("R9 falling latched", d, 32'h0000_0001);
    rd(8'h1C, d); check("R9 rising sticky, disabled pin ignored", d, 32'h0000_0001);
    wr(8'h1C, 32'hFFFF_0000); rd(8'h1C, d); check("R10 upper half ignored", d, 32'h0000_0001);
    wr(8'h1C, 32'h0000_0001); rd(8'h1C, d); check("R10 write-one clears", d, 32'h0);
    rd(8'h20, d); check("R10 other status kept", d, 32'h0000_0001);
  endtask

  task automatic t_race();
    logic [31:0] d;
    do_reset();
    wr(8'h08, 32'h0000_0001);
    pin_in = 32'h1; repeat (5) @(negedge clk);
    pin_in = 32'h0; repeat (5) @(negedge clk);
    @(negedge clk); pin_in = 32'h1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h1;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    rd(8'h1C, d); check("R11 edge beats clear", d, 32'h0000_0001);
    wr(8'h1C, 32'h0000_0001); rd(8'h1C, d); check("R11 later clear empties", d, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_set_clear(); t_reserved(); t_drive();
        t_readback(); t_edges(); t_race();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule